// File: doc/BRIEF.md
# Serial Register-Bank Access Chain

This block gives a boundary-scan debugger read and write access to a bank of 32-bit registers through a single 38-bit serial chain. The chain sits between the test data input and output. It reacts only while the scan-chain selector holds chain number 2 and the current instruction is the internal-test instruction. The tap controller supplies its state strobes as single-cycle, clock-synchronous pulses: one for capture, one for shift and one for update.

The debugger shifts in a word made of three parts: a direction flag, a 5-bit register address and a 32-bit data value. When the update strobe arrives, the block carries out the access that the word describes. A write stores the data field into the addressed register. A read replaces the data field with the register contents, so that the next shift brings the value out.

The bank has 32 addresses:
- `RW_COUNT` writable registers, starting at address 0.
- Two read-only words directly after them.
- A read-zero hole for the addresses that remain.

Top module: `regbank_scan_port`

## Requirements
- R1: The chain is active only when `chain_num` equals 2 and `intest` is 1. While it is inactive, `shift_dr` and `update_dr` change neither the chain nor any register, and `tdo` is 0.
- R2: The chain fields are laid out as follows: bit 37 is the write flag, bits 36:32 are the address and bits 31:0 are the data. On each active `shift_dr` cycle the chain moves one place toward `tdo`, `tdi` enters bit 37, and `tdo` shows bit 0. Data bit 0 therefore leaves first and the flag leaves last.
- R3: An active `capture_dr` pulse leaves the chain unchanged.
- R4: An active `update_dr` with bit 37 = 1 writes bits 31:0 into the register at the address in bits 36:32, if that address is below `RW_COUNT` (default 28). The chain is left unchanged.
- R5: An active `update_dr` with bit 37 = 0 loads the read value of the addressed register into bits 31:0, one clock later. Bits 37:32 keep their value.
- R6: Writes to addresses `RW_COUNT` and above are ignored.
- R7: Address `RW_COUNT` reads as `ID_WORD` (default 32'h3C5A_0F02), and address `RW_COUNT`+1 reads as `RW_COUNT`, zero-extended. All other addresses from `RW_COUNT`+2 to 31 read as zero.
- R8: After reset, the chain and all writable registers hold zero and `tdo` is 0.
- R9: Writable registers are independent of each other. A read returns the value last written to that address, or zero if it has never been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_num | input | 4 | Currently selected scan chain number |
| intest | input | 1 | 1 while the internal-test instruction is current |
| capture_dr | input | 1 | Tap controller is in the capture-data state |
| shift_dr | input | 1 | Tap controller is in the shift-data state |
| update_dr | input | 1 | Tap controller is in the update-data state |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out (chain bit 0 while active, else 0) |

## Verification
Any wrong internal state in the chain reaches `tdo` during the next scan, which takes at most 38 shift cycles. Each scanned-out word is compared with a bit-exact prediction of the previous chain contents. A register holding a wrong value, or a write that should have been blocked but was not, becomes visible only when that address is read. For this reason the bench always follows each write with a read of the same address and then a scan. This covers the read-only and unimplemented addresses and the writes issued while the chain is inactive. Within that scan the error appears at the bit position of the faulty field.

// File: rtl/regbank_scan_pkg.sv
package regbank_scan_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int CHAIN_W   = DATA_W + ADDR_W + 1;
    localparam int NUM_ADDR  = 1 << ADDR_W;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } chain_t;
endpackage

// File: rtl/rbs_access_ctrl.sv
module rbs_access_ctrl #(
    parameter int SEL_W    = 4,
    parameter int CHAIN_ID = 2
) (
    input  logic [SEL_W-1:0] chain_num,
    input  logic             intest,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             wr_flag,
    output logic             active,
    output logic             do_shift,
    output logic             do_read,
    output logic             do_write
);
    always_comb begin
        active   = (chain_num == SEL_W'(CHAIN_ID)) && intest;
        // Update takes priority over shift; capture performs no action.
        do_shift = active && shift_dr && !update_dr;
        do_read  = active && update_dr && !wr_flag;
        do_write = active && update_dr && wr_flag;
    end
endmodule

// File: rtl/rbs_shift_chain.sv
module rbs_shift_chain
    import regbank_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic              do_shift,
    input  logic              do_load,
    input  logic [DATA_W-1:0] load_data,
    output chain_t            chain_q
);
    chain_t chain_d;

    always_comb begin
        chain_d = chain_q;
        if (do_shift) begin
            chain_d = chain_t'({tdi, chain_q[CHAIN_W-1:1]});
        end else if (do_load) begin
            chain_d.data = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/rbs_reg_bank.sv
module rbs_reg_bank
    import regbank_scan_pkg::*;
#(
    parameter int          RW_COUNT = 28,
    parameter logic [31:0] ID_WORD  = 32'h3C5A_0F02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int RO_ID   = RW_COUNT;
    localparam int RO_SIZE = RW_COUNT + 1;

    logic [DATA_W-1:0] mem_q    [RW_COUNT];
    logic [DATA_W-1:0] mem_d    [RW_COUNT];
    logic [DATA_W-1:0] rd_table [NUM_ADDR];

    for (genvar i = 0; i < RW_COUNT; i++) begin : g_rw
        always_comb begin
            mem_d[i] = mem_q[i];
            if (we && addr == ADDR_W'(i)) mem_d[i] = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    for (genvar j = 0; j < NUM_ADDR; j++) begin : g_rd
        if (j < RW_COUNT) begin : g_mem
            assign rd_table[j] = mem_q[j];
        end else if (j == RO_ID) begin : g_id
            assign rd_table[j] = DATA_W'(ID_WORD);
        end else if (j == RO_SIZE) begin : g_size
            assign rd_table[j] = DATA_W'(RW_COUNT);
        end else begin : g_hole
            assign rd_table[j] = '0;
        end
    end

    always_comb rdata = rd_table[addr];
endmodule

// File: rtl/regbank_scan_port.sv
module regbank_scan_port
    import regbank_scan_pkg::*;
#(
    parameter int          SEL_W    = 4,
    parameter int          CHAIN_ID = 2,
    parameter int          RW_COUNT = 28,
    parameter logic [31:0] ID_WORD  = 32'h3C5A_0F02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] chain_num,
    input  logic             intest,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    output logic             tdo
);
    chain_t            chain_w;
    logic              active_w;
    logic              do_shift_w;
    logic              do_read_w;
    logic              do_write_w;
    logic [DATA_W-1:0] rdata_w;

    rbs_access_ctrl #(.SEL_W(SEL_W), .CHAIN_ID(CHAIN_ID)) u_ctrl (
        .chain_num (chain_num),
        .intest    (intest),
        .shift_dr  (shift_dr),
        .update_dr (update_dr),
        .wr_flag   (chain_w.wr),
        .active    (active_w),
        .do_shift  (do_shift_w),
        .do_read   (do_read_w),
        .do_write  (do_write_w)
    );

    rbs_shift_chain u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .tdi       (tdi),
        .do_shift  (do_shift_w),
        .do_load   (do_read_w),
        .load_data (rdata_w),
        .chain_q   (chain_w)
    );

    rbs_reg_bank #(.RW_COUNT(RW_COUNT), .ID_WORD(ID_WORD)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_write_w),
        .addr  (chain_w.addr),
        .wdata (chain_w.data),
        .rdata (rdata_w)
    );

    always_comb tdo = active_w ? chain_w.data[0] : 1'b0;
endmodule

// File: rtl/regbank_scan_checker.sv
module regbank_scan_checker
    import regbank_scan_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               active,
    input logic               capture_dr,
    input logic               shift_dr,
    input logic               update_dr,
    input logic               tdi,
    input logic               we,
    input logic [CHAIN_W-1:0] chain
);
    // R1: an idle chain holds its contents
    a_r1_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(chain));

    // R1: no register write while idle
    a_r1_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (active && update_dr && chain[CHAIN_W-1]));

    // R2: a shift moves tdi into the top bit
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && shift_dr && !update_dr) |=>
            chain == {$past(tdi), $past(chain[CHAIN_W-1:1])});

    // R3: capture takes no action
    a_r3_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && capture_dr && !shift_dr && !update_dr) |=> $stable(chain));

    // R4: a write update leaves the chain alone
    a_r4_write_keeps_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (active && update_dr && chain[CHAIN_W-1]) |=> $stable(chain));

    // R5: a read update keeps the flag and address
    a_r5_read_keeps_header: assert property (@(posedge clk) disable iff (!rst_n)
        (active && update_dr && !chain[CHAIN_W-1]) |=>
            chain[CHAIN_W-1:DATA_W] == $past(chain[CHAIN_W-1:DATA_W]));
endmodule

bind regbank_scan_port regbank_scan_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active_w),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .we         (do_write_w),
    .chain      (chain_w)
);

// File: tb/regbank_scan_port_tb.sv
module regbank_scan_port_tb;
    localparam int          RW_CNT = 28;
    localparam logic [31:0] IDW    = 32'h3C5A_0F02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chain_num = 4'd0;
    logic       intest = 1'b0;
    logic       capture_dr = 1'b0;
    logic       shift_dr = 1'b0;
    logic       update_dr = 1'b0;
    logic       tdi = 1'b0;
    logic       tdo;

    always #2 clk = ~clk;

    regbank_scan_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_num  (chain_num),
        .intest     (intest),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .tdo        (tdo)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [37:0] model_chain = '0;
    logic [31:0] model_regs [32];
    logic [37:0] exp_q [$];
    string       tag_q [$];
    logic [37:0] got_word;
    event        scan_done;

    task automatic check(input string tag, input logic [37:0] got, input logic [37:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mdl_read(input logic [4:0] a);
        if (int'(a) < RW_CNT)       return model_regs[a];
        else if (int'(a) == RW_CNT) return IDW;
        else if (int'(a) == RW_CNT + 1) return 32'(RW_CNT);
        else return 32'h0;
    endfunction

    function automatic bit is_active();
        return chain_num == 4'd2 && intest;
    endfunction

    function automatic logic [37:0] mk(input bit wr, input logic [4:0] a, input logic [31:0] d);
        return {wr, a, d};
    endfunction

    // Driver: predicts the word that will leave tdo, then shifts a new one in.
    task automatic scan(input logic [37:0] word_in, input string tag);
        logic [37:0] got;
        if (is_active()) begin
            exp_q.push_back(model_chain);
            model_chain = word_in;
        end else begin
            exp_q.push_back('0);
        end
        tag_q.push_back(tag);
        for (int i = 0; i < 38; i++) begin
            @(negedge clk);
            got[i]   = tdo;
            tdi      = word_in[i];
            shift_dr = 1'b1;
        end
        @(negedge clk);
        shift_dr = 1'b0;
        got_word = got;
        -> scan_done;
    endtask

    task automatic update();
        if (is_active()) begin
            if (model_chain[37]) begin
                if (int'(model_chain[36:32]) < RW_CNT)
                    model_regs[model_chain[36:32]] = model_chain[31:0];
            end else begin
                model_chain[31:0] = mdl_read(model_chain[36:32]);
            end
        end
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    // Monitor: compares each scanned-out word with the queued prediction.
    always @(scan_done) begin
        logic [37:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, got_word, e);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) model_regs[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 R1 tdo idle after reset", 38'(tdo), 38'd0);

        chain_num = 4'd2;
        intest    = 1'b1;
        @(negedge clk);
        check("R8 tdo zero after reset when active", 38'(tdo), 38'd0);

        // R4/R5/R8: first scan shows the reset chain
        scan(mk(1, 5'd5, 32'hA5A5_1234), "R8 R2 reset chain out");
        update();
        scan(mk(0, 5'd5, 32'h0), "R4 R2 write word returned");
        update();
        scan(mk(1, 5'd6, 32'h0F0F_F0F0), "R5 R4 read back reg5");
        update();
        scan(mk(0, 5'd6, 32'h0), "R2 pattern out");
        update();
        scan(mk(0, 5'd5, 32'h0), "R9 read reg6");
        update();
        scan(mk(0, 5'd9, 32'hFFFF_FFFF), "R9 reg5 kept");
        update();

        // R3: capture between scans leaves the chain alone
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        scan(mk(1, 5'd27, 32'h8000_0001), "R3 R9 capture no-op, unwritten reg9 zero");
        update();
        scan(mk(0, 5'd27, 32'h1357_9BDF), "R4 top writable address write");
        update();

        // R6/R7: read-only and hole addresses
        scan(mk(1, 5'd28, 32'hDEAD_BEEF), "R4 read reg27");
        update();
        scan(mk(0, 5'd28, 32'h0), "R6 write ro id");
        update();
        scan(mk(1, 5'd29, 32'h1111_1111), "R7 R6 id word after write");
        update();
        scan(mk(0, 5'd29, 32'h0), "R6 write ro size");
        update();
        scan(mk(1, 5'd31, 32'h2222_2222), "R7 size word");
        update();
        scan(mk(0, 5'd31, 32'hFFFF_FFFF), "R6 write hole");
        update();
        scan(mk(0, 5'd30, 32'h7777_7777), "R7 hole 31 reads zero");
        update();

        // R1: wrong chain number
        chain_num = 4'd3;
        @(negedge clk);
        check("R1 tdo quiet other chain", 38'(tdo), 38'd0);
        scan(mk(1, 5'd5, 32'hFFFF_FFFF), "R1 inactive chain scan");
        update();
        // R1: wrong instruction
        chain_num = 4'd2;
        intest    = 1'b0;
        scan(mk(1, 5'd6, 32'hFFFF_FFFF), "R1 inactive instr scan");
        update();
        intest = 1'b1;
        scan(mk(0, 5'd5, 32'h0), "R1 R7 chain held while idle, hole 30 zero");
        update();
        scan(mk(0, 5'd6, 32'h0), "R1 reg5 not written idle");
        update();
        scan(mk(0, 5'd0, 32'h0), "R1 reg6 not written idle");
        update();
        scan(mk(0, 5'd0, 32'h0), "R9 reg0 zero");

        repeat (4) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule